// File: doc/BRIEF.md
# IPv4 Transmit Frame Builder

The block turns one send request into one complete Ethernet frame that carries an IPv4 packet, and presents it one byte per cycle. A single-cycle start pulse captures the protocol number, the payload length and the destination IPv4 address. For a unicast destination, the block asks an external address resolver for the destination MAC address. For the limited broadcast address 255.255.255.255 it skips the lookup and uses the all-ones MAC address.

With the destination MAC known, the block raises a request to a shared MAC transmit channel and waits for the grant. After the grant it streams 34 header bytes: the 14-byte Ethernet header, then a 20-byte IPv4 header without options. The IPv4 header checksum comes from the captured fields before the first header byte leaves. The block then forwards the user's payload bytes. Back-pressure from the MAC reaches the user through a ready signal.

A 2-bit status shows the progress of the latest request. The MAC's CRC, fragmentation and channel arbitration belong to other blocks.

Top module: `ipv4_tx_framer`

## Requirements
- R1: While reset is applied and after it is released, lookup_req, chan_req, pl_ready, tx_valid and tx_last are low and status is 2'b00 (idle).
- R2: One cycle after a start pulse with a destination other than 255.255.255.255, lookup_req is high, lookup_ip equals the captured destination and status is 2'b01 (sending).
- R3: In the cycle after lookup_done is sampled high during a lookup, lookup_req is low and chan_req is high. The lookup_mac value sampled with it becomes the frame's destination MAC.
- R4: For destination 255.255.255.255, lookup_req never rises. One cycle after start, chan_req is high and status is 2'b01. The destination MAC is 48'hFFFF_FFFF_FFFF.
- R5: tx_valid stays low while chan_grant is low and while no frame is in progress. Header bytes start in the cycle after the grant is sampled.
- R6: The frame is sent in wire order:
  - bytes 0-5 are the destination MAC, most significant byte first;
  - bytes 6-11 are local_mac;
  - bytes 12-13 are 8'h08, 8'h00;
  - bytes 14-33 are the IPv4 header: 8'h45, 8'h00, total length = payload length + 20, identification 16'h0000, flags/fragment 16'h4000, TTL 8'd64, protocol, checksum, local_ip, destination IP;
  - all multi-byte fields are big-endian.
- R7: A byte leaves only in a cycle where tx_valid and tx_ready are both high. While tx_ready is low the header does not advance. tx_first is high only on byte 0.
- R8: pl_ready is low until all 34 header bytes have been accepted. During the payload it equals tx_ready.
- R9: During the payload, tx_valid equals pl_valid and tx_data equals pl_data. pl_last on an accepted byte raises tx_last on that same byte, which ends the frame.
- R10: In the cycle after the last byte is accepted, chan_req is low and status is 2'b10 (sent).
- R11: If lookup_err is sampled high during a lookup, status becomes 2'b11 (error) on the next cycle, the block returns to idle, and chan_req and tx_valid stay low.
- R12: Bytes 24-25 hold the one's complement of the one's-complement sum of the ten 16-bit header words, with the checksum field taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle send request, accepted when idle |
| hdr_proto | input | 8 | IPv4 protocol number |
| hdr_len | input | 16 | Payload length in bytes |
| hdr_dst_ip | input | 32 | Destination IPv4 address |
| local_ip | input | 32 | Source IPv4 address |
| local_mac | input | 48 | Source MAC address |
| lookup_req | output | 1 | Address resolution request |
| lookup_ip | output | 32 | Address to resolve |
| lookup_done | input | 1 | Resolver found the MAC |
| lookup_err | input | 1 | Resolver failed |
| lookup_mac | input | 48 | Resolved MAC address |
| chan_req | output | 1 | Transmit channel request, held for the whole frame |
| chan_grant | input | 1 | Transmit channel granted |
| tx_ready | input | 1 | MAC accepts a byte |
| tx_valid | output | 1 | Output byte valid |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Last byte of frame |
| tx_data | output | 8 | Output byte |
| pl_valid | input | 1 | Payload byte valid |
| pl_last | input | 1 | Final payload byte |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Block accepts a payload byte |
| status | output | 2 | 00 idle, 01 sending, 10 sent, 11 error |

## Verification
The bench drives tx_ready with a stop-and-go pattern while the header streams. A header counter that advanced on valid alone would skip or repeat bytes, and the byte-by-byte comparison catches that. A broadcast request must never pulse lookup_req, and a unicast request is resolved only after several idle cycles, so a block that requested the channel early would show chan_req during the lookup. A payload gap with pl_valid low finds a design that forwards stale data. A resolver error must leave chan_req low, or the channel would be claimed for a frame that can never be built. One-byte and multi-byte payloads change the total length and the checksum, so each frame checks the arithmetic with new values.

// File: rtl/ipv4_tx_pkg.sv
package ipv4_tx_pkg;
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 16;
  localparam int IPV4_W      = 32;
  localparam int MAC_W       = 48;
  localparam int ETH_HDR_B   = 14;
  localparam int IP_HDR_B    = 20;
  localparam int FRAME_HDR_B = ETH_HDR_B + IP_HDR_B;
  localparam int HDR_IDX_W   = $clog2(FRAME_HDR_B);

  typedef enum logic [1:0] {
    TXS_NONE    = 2'b00,
    TXS_SENDING = 2'b01,
    TXS_SENT    = 2'b10,
    TXS_ERROR   = 2'b11
  } tx_status_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LOOKUP,
    FS_CHREQ,
    FS_HDR,
    FS_PAY
  } fsm_e;
endpackage

// File: rtl/ipv4_hdr_csum.sv
module ipv4_hdr_csum
  import ipv4_tx_pkg::*;
#(
  parameter logic [15:0] IP_ID         = 16'h0000,
  parameter logic [15:0] IP_FLAGS_FRAG = 16'h4000,
  parameter logic [7:0]  IP_TTL        = 8'd64
) (
  input  logic [WORD_W-1:0] total_len,
  input  logic [BYTE_W-1:0] proto,
  input  logic [IPV4_W-1:0] src_ip,
  input  logic [IPV4_W-1:0] dst_ip,
  output logic [WORD_W-1:0] csum
);
  localparam int SUM_W = WORD_W + 4;

  logic [SUM_W-1:0]  sum;
  logic [WORD_W:0]   fold1;
  logic [WORD_W:0]   fold2;

  always_comb begin
    sum = {4'b0, 16'h4500} + {4'b0, total_len} + {4'b0, IP_ID}
        + {4'b0, IP_FLAGS_FRAG} + {4'b0, IP_TTL, proto}
        + {4'b0, src_ip[31:16]} + {4'b0, src_ip[15:0]}
        + {4'b0, dst_ip[31:16]} + {4'b0, dst_ip[15:0]};
    fold1 = {1'b0, sum[WORD_W-1:0]} + {13'b0, sum[SUM_W-1:WORD_W]};
    fold2 = {1'b0, fold1[WORD_W-1:0]} + {16'b0, fold1[WORD_W]};
    csum  = ~fold2[WORD_W-1:0];
  end
endmodule

// File: rtl/ipv4_hdr_byte.sv
module ipv4_hdr_byte
  import ipv4_tx_pkg::*;
#(
  parameter logic [15:0] IP_ID         = 16'h0000,
  parameter logic [15:0] IP_FLAGS_FRAG = 16'h4000,
  parameter logic [7:0]  IP_TTL        = 8'd64
) (
  input  logic [HDR_IDX_W-1:0] idx,
  input  logic [MAC_W-1:0]     dst_mac,
  input  logic [MAC_W-1:0]     src_mac,
  input  logic [WORD_W-1:0]    total_len,
  input  logic [BYTE_W-1:0]    proto,
  input  logic [WORD_W-1:0]    csum,
  input  logic [IPV4_W-1:0]    src_ip,
  input  logic [IPV4_W-1:0]    dst_ip,
  output logic [BYTE_W-1:0]    hbyte
);
  always_comb begin
    hbyte = '0;
    case (idx)
      6'd0:  hbyte = dst_mac[47:40];
      6'd1:  hbyte = dst_mac[39:32];
      6'd2:  hbyte = dst_mac[31:24];
      6'd3:  hbyte = dst_mac[23:16];
      6'd4:  hbyte = dst_mac[15:8];
      6'd5:  hbyte = dst_mac[7:0];
      6'd6:  hbyte = src_mac[47:40];
      6'd7:  hbyte = src_mac[39:32];
      6'd8:  hbyte = src_mac[31:24];
      6'd9:  hbyte = src_mac[23:16];
      6'd10: hbyte = src_mac[15:8];
      6'd11: hbyte = src_mac[7:0];
      6'd12: hbyte = 8'h08;
      6'd13: hbyte = 8'h00;
      6'd14: hbyte = 8'h45;
      6'd15: hbyte = 8'h00;
      6'd16: hbyte = total_len[15:8];
      6'd17: hbyte = total_len[7:0];
      6'd18: hbyte = IP_ID[15:8];
      6'd19: hbyte = IP_ID[7:0];
      6'd20: hbyte = IP_FLAGS_FRAG[15:8];
      6'd21: hbyte = IP_FLAGS_FRAG[7:0];
      6'd22: hbyte = IP_TTL;
      6'd23: hbyte = proto;
      6'd24: hbyte = csum[15:8];
      6'd25: hbyte = csum[7:0];
      6'd26: hbyte = src_ip[31:24];
      6'd27: hbyte = src_ip[23:16];
      6'd28: hbyte = src_ip[15:8];
      6'd29: hbyte = src_ip[7:0];
      6'd30: hbyte = dst_ip[31:24];
      6'd31: hbyte = dst_ip[23:16];
      6'd32: hbyte = dst_ip[15:8];
      6'd33: hbyte = dst_ip[7:0];
      default: hbyte = '0;
    endcase
  end
endmodule

// File: rtl/ipv4_tx_framer.sv
module ipv4_tx_framer
  import ipv4_tx_pkg::*;
#(
  parameter logic [15:0] IP_ID         = 16'h0000,
  parameter logic [15:0] IP_FLAGS_FRAG = 16'h4000,
  parameter logic [7:0]  IP_TTL        = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] hdr_proto,
  input  logic [WORD_W-1:0] hdr_len,
  input  logic [IPV4_W-1:0] hdr_dst_ip,
  input  logic [IPV4_W-1:0] local_ip,
  input  logic [MAC_W-1:0]  local_mac,
  output logic              lookup_req,
  output logic [IPV4_W-1:0] lookup_ip,
  input  logic              lookup_done,
  input  logic              lookup_err,
  input  logic [MAC_W-1:0]  lookup_mac,
  output logic              chan_req,
  input  logic              chan_grant,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              pl_valid,
  input  logic              pl_last,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              pl_ready,
  output logic [1:0]        status
);
  localparam logic [HDR_IDX_W-1:0] LAST_HDR = HDR_IDX_W'(FRAME_HDR_B - 1);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  fsm_e                 st_q, st_d;
  tx_status_e           stat_q, stat_d;
  logic [HDR_IDX_W-1:0] idx_q, idx_d;
  logic [BYTE_W-1:0]    proto_q;
  logic [WORD_W-1:0]    len_q;
  logic [IPV4_W-1:0]    dip_q;
  logic [MAC_W-1:0]     dmac_q, dmac_d;
  logic                 cap_hdr, dmac_en, bcast;
  logic                 in_hdr, in_pay;
  logic [WORD_W-1:0]    total_len, csum;
  logic [BYTE_W-1:0]    hbyte;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign bcast = (hdr_dst_ip == '1);

  always_comb begin
    st_d    = st_q;
    stat_d  = stat_q;
    idx_d   = idx_q;
    cap_hdr = 1'b0;
    dmac_en = 1'b0;
    dmac_d  = dmac_q;
    case (st_q)
      FS_IDLE: if (start) begin
        cap_hdr = 1'b1;
        stat_d  = TXS_SENDING;
        if (bcast) begin
          dmac_en = 1'b1;
          dmac_d  = '1;
          st_d    = FS_CHREQ;
        end else begin
          st_d    = FS_LOOKUP;
        end
      end
      FS_LOOKUP: begin
        if (lookup_err) begin
          stat_d = TXS_ERROR;
          st_d   = FS_IDLE;
        end else if (lookup_done) begin
          dmac_en = 1'b1;
          dmac_d  = lookup_mac;
          st_d    = FS_CHREQ;
        end
      end
      FS_CHREQ: if (chan_grant) begin
        idx_d = '0;
        st_d  = FS_HDR;
      end
      FS_HDR: if (tx_ready) begin
        if (idx_q == LAST_HDR) st_d = FS_PAY;
        else                   idx_d = idx_q + 1'b1;
      end
      FS_PAY: if (pl_valid && tx_ready && pl_last) begin
        stat_d = TXS_SENT;
        st_d   = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      stat_q <= TXS_NONE;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q <= '0;
      len_q   <= '0;
      dip_q   <= '0;
    end else if (cap_hdr) begin
      proto_q <= hdr_proto;
      len_q   <= hdr_len;
      dip_q   <= hdr_dst_ip;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      dmac_q <= '0;
    else if (dmac_en) dmac_q <= dmac_d;
  end

  assign total_len = len_q + WORD_W'(IP_HDR_B);

  ipv4_hdr_csum #(
    .IP_ID(IP_ID), .IP_FLAGS_FRAG(IP_FLAGS_FRAG), .IP_TTL(IP_TTL)
  ) u_csum (
    .total_len(total_len), .proto(proto_q),
    .src_ip(local_ip), .dst_ip(dip_q), .csum(csum)
  );

  ipv4_hdr_byte #(
    .IP_ID(IP_ID), .IP_FLAGS_FRAG(IP_FLAGS_FRAG), .IP_TTL(IP_TTL)
  ) u_hbyte (
    .idx(idx_q), .dst_mac(dmac_q), .src_mac(local_mac),
    .total_len(total_len), .proto(proto_q), .csum(csum),
    .src_ip(local_ip), .dst_ip(dip_q), .hbyte(hbyte)
  );

  assign in_hdr     = (st_q == FS_HDR);
  assign in_pay     = (st_q == FS_PAY);
  assign lookup_req = (st_q == FS_LOOKUP);
  assign lookup_ip  = dip_q;
  assign chan_req   = (st_q == FS_CHREQ) || in_hdr || in_pay;
  assign tx_valid   = in_hdr || (in_pay && pl_valid);
  assign tx_first   = in_hdr && (idx_q == '0);
  assign tx_last    = in_pay && pl_valid && pl_last;
  assign tx_data    = in_hdr ? hbyte : pl_data;
  assign pl_ready   = in_pay && tx_ready;
  assign status     = stat_q;
endmodule

// File: rtl/ipv4_tx_framer_chk.sv
module ipv4_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lookup_req,
  input logic       lookup_done,
  input logic       lookup_err,
  input logic       chan_req,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic       tx_first,
  input logic       tx_last,
  input logic       pl_ready,
  input logic [1:0] status
);
  // R2: a lookup only starts while the request is in progress
  a_r2_lookup_sending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lookup_req) |-> status == 2'b01);

  // R3: lookup and channel request never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(lookup_req && chan_req));

  // R5: no byte leaves without the channel being requested
  a_r5_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> chan_req);

  // R7: a stalled first byte stays first
  a_r7_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_first && !tx_ready) |=> tx_first);

  // R8: user ready never runs ahead of the MAC
  a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> tx_ready);

  // R9: last is only flagged on a valid byte
  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R10: an accepted last byte releases the channel and reports sent
  a_r10_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_ready) |=> (!chan_req && status == 2'b10));

  // R11: resolver failure reports error and never claims the channel
  a_r11_error: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_req && lookup_err) |=> (status == 2'b11 && !chan_req));

  // R3: a successful lookup moves on to the channel request
  a_r3_found: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_req && lookup_done && !lookup_err) |=> chan_req);
endmodule

bind ipv4_tx_framer ipv4_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_req(lookup_req),
  .lookup_done(lookup_done), .lookup_err(lookup_err),
  .chan_req(chan_req), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_first(tx_first), .tx_last(tx_last), .pl_ready(pl_ready),
  .status(status)
);

// File: tb/tb_ipv4_tx_framer.sv
`timescale 1ns/1ps
module tb_ipv4_tx_framer;
  logic        clk = 1'b0;
  logic        rst_n, start, lookup_done, lookup_err, chan_grant, tx_ready;
  logic        pl_valid, pl_last;
  logic [7:0]  hdr_proto, pl_data, tx_data;
  logic [15:0] hdr_len;
  logic [31:0] hdr_dst_ip, local_ip, lookup_ip;
  logic [47:0] local_mac, lookup_mac;
  logic        lookup_req, chan_req, tx_valid, tx_first, tx_last, pl_ready;
  logic [1:0]  status;

  int checks = 0, errors = 0;
  int hdr_left = 0, popped = 0, rdy_mode = 0, cyc = 0;
  bit mon_en = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  ipv4_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_proto(hdr_proto),
    .hdr_len(hdr_len), .hdr_dst_ip(hdr_dst_ip), .local_ip(local_ip),
    .local_mac(local_mac), .lookup_req(lookup_req), .lookup_ip(lookup_ip),
    .lookup_done(lookup_done), .lookup_err(lookup_err),
    .lookup_mac(lookup_mac), .chan_req(chan_req), .chan_grant(chan_grant),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_data(tx_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .pl_data(pl_data), .pl_ready(pl_ready),
    .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string byte_req(input int i);
    if (i == 24 || i == 25) return "R12";
    return "R6";
  endfunction

  // Expected frame from the requirements
  task automatic build_frame(input logic [47:0] dmac, input logic [7:0] proto,
                             input logic [31:0] dip, input int n);
    logic [7:0] h[34];
    logic [15:0] tl;
    int unsigned s;
    tl = 16'(n + 20);
    for (int i = 0; i < 6; i++) begin
      h[i]     = dmac[8*(5-i) +: 8];
      h[6 + i] = local_mac[8*(5-i) +: 8];
    end
    h[12] = 8'h08; h[13] = 8'h00; h[14] = 8'h45; h[15] = 8'h00;
    h[16] = tl[15:8]; h[17] = tl[7:0]; h[18] = 8'h00; h[19] = 8'h00;
    h[20] = 8'h40; h[21] = 8'h00; h[22] = 8'd64; h[23] = proto;
    h[24] = 8'h00; h[25] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      h[26 + i] = local_ip[8*(3-i) +: 8];
      h[30 + i] = dip[8*(3-i) +: 8];
    end
    s = 0;
    for (int i = 14; i < 34; i += 2) s += {h[i], h[i+1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    s = ~s;
    h[24] = s[15:8]; h[25] = s[7:0];
    exp_q.delete();
    for (int i = 0; i < 34; i++) exp_q.push_back(h[i]);
    for (int i = 0; i < n; i++) exp_q.push_back(8'(proto + 8'h30 + 8'(i)));
    hdr_left = 34;
    popped = 0;
  endtask

  // Cycle-by-cycle comparison against the expected queue
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) chk(!tx_valid, "R5", "tx_valid idle", tx_valid, 0);
      else begin
        if (!chan_grant) chk(!tx_valid, "R5", "tx_valid before grant", tx_valid, 0);
        if (hdr_left > 0) chk(!pl_ready, "R8", "pl_ready in header", pl_ready, 0);
        else begin
          chk(pl_ready == tx_ready, "R8", "pl_ready follows", pl_ready, tx_ready);
          chk(tx_valid == pl_valid, "R9", "tx_valid follows", tx_valid, pl_valid);
        end
        if (tx_valid && tx_ready) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, (popped < 34) ? byte_req(popped) : "R9",
              $sformatf("byte %0d", popped), tx_data, e);
          chk(tx_first == (popped == 0), "R7", "tx_first", tx_first, popped == 0);
          chk(tx_last == (exp_q.size() == 0), "R9", "tx_last", tx_last,
              exp_q.size() == 0);
          if (hdr_left > 0) hdr_left--;
          popped++;
        end
      end
    end
  end

  // MAC ready pattern
  initial begin
    tx_ready = 1'b0;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end
  end

  task automatic run_frame(input logic [47:0] mac, input bit bcast,
                           input logic [7:0] proto, input logic [31:0] dip,
                           input int n, input int lwait, input int gwait,
                           input bit gap);
    build_frame(bcast ? 48'hFFFF_FFFF_FFFF : mac, proto, dip, n);
    @(posedge clk); #1;
    hdr_proto = proto; hdr_len = 16'(n); hdr_dst_ip = dip; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    if (!bcast) begin
      chk(lookup_req == 1'b1, "R2", "lookup_req", lookup_req, 1);
      chk(status == 2'b01, "R2", "status", status, 1);
      chk(lookup_ip == dip, "R2", "lookup_ip", lookup_ip, dip);
      repeat (lwait) begin
        @(negedge clk);
        chk(!chan_req, "R3", "chan_req during lookup", chan_req, 0);
      end
      @(posedge clk); #1;
      lookup_done = 1'b1; lookup_mac = mac;
      @(posedge clk); #1;
      lookup_done = 1'b0; lookup_mac = '0;
      @(negedge clk);
      chk(!lookup_req, "R3", "lookup_req cleared", lookup_req, 0);
      chk(chan_req, "R3", "chan_req raised", chan_req, 1);
    end else begin
      chk(!lookup_req, "R4", "no lookup", lookup_req, 0);
      chk(chan_req, "R4", "chan_req", chan_req, 1);
      chk(status == 2'b01, "R4", "status", status, 1);
    end
    repeat (gwait) @(posedge clk);
    @(negedge clk);
    chk(!tx_valid, "R5", "no output before grant", tx_valid, 0);
    @(posedge clk); #1;
    chan_grant = 1'b1;
    for (int i = 0; i < n; i++) begin
      pl_valid = 1'b1; pl_data = 8'(proto + 8'h30 + 8'(i)); pl_last = (i == n - 1);
      @(negedge clk);
      while (!pl_ready) @(negedge clk);
      @(posedge clk); #1;
      if (gap && i == 1) begin
        pl_valid = 1'b0; pl_data = 8'hEE; pl_last = 1'b1;
        repeat (2) @(posedge clk); #1;
      end
    end
    pl_valid = 1'b0; pl_last = 1'b0;
    @(negedge clk);
    chk(!chan_req, "R10", "chan_req released", chan_req, 0);
    chk(status == 2'b10, "R10", "status sent", status, 2);
    chk(exp_q.size() == 0, "R9", "bytes outstanding", exp_q.size(), 0);
    @(posedge clk); #1;
    chan_grant = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; lookup_done = 1'b0; lookup_err = 1'b0;
    chan_grant = 1'b0; pl_valid = 1'b0; pl_last = 1'b0; pl_data = '0;
    hdr_proto = '0; hdr_len = '0; hdr_dst_ip = '0; lookup_mac = '0;
    local_ip = 32'hC0A8_0509; local_mac = 48'h0023_2021_2223;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!chan_req && !tx_valid && status == 2'b00, "R1", "during reset",
        {chan_req, tx_valid, status}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!lookup_req, "R1", "lookup_req", lookup_req, 0);
    chk(!chan_req, "R1", "chan_req", chan_req, 0);
    chk(!pl_ready, "R1", "pl_ready", pl_ready, 0);
    chk(!tx_valid, "R1", "tx_valid", tx_valid, 0);
    chk(!tx_last, "R1", "tx_last", tx_last, 0);
    chk(status == 2'b00, "R1", "status", status, 0);
    mon_en = 1;

    // Unicast, slow lookup and grant, MAC stalls, payload gap
    rdy_mode = 1;
    run_frame(48'h0504_2327_1016, 1'b0, 8'h35, 32'hC012_3478, 8, 6, 5, 1'b1);
    // Broadcast, MAC always ready
    rdy_mode = 0;
    run_frame(48'h0, 1'b1, 8'h11, 32'hFFFF_FFFF, 6, 0, 1, 1'b0);
    // Unicast, one payload byte, stalls
    rdy_mode = 1;
    run_frame(48'hA1B2_C3D4_E5F6, 1'b0, 8'h06, 32'h0A00_00FE, 1, 0, 0, 1'b0);

    // Resolver failure
    @(posedge clk); #1;
    hdr_dst_ip = 32'h0A01_0203; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(lookup_req, "R11", "lookup_req before error", lookup_req, 1);
    @(posedge clk); #1;
    lookup_err = 1'b1;
    @(posedge clk); #1;
    lookup_err = 1'b0;
    @(negedge clk);
    chk(status == 2'b11, "R11", "status error", status, 3);
    chk(!lookup_req, "R11", "idle after error", lookup_req, 0);
    chan_grant = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!chan_req && !tx_valid, "R11", "no channel after error",
          {chan_req, tx_valid}, 0);
    end
    chan_grant = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule